// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Controller

This block is the device side of a single receive ring. Host software keeps a power-of-two ring of buffer descriptors in memory, one 32-bit word per entry. Each descriptor carries bits [35:8] of a 256-byte aligned buffer address. Software hands descriptors to the device by advancing a write index. The controller works through the ring one descriptor at a time:

- It fetches the next descriptor through a request/grant memory port.
- It counts the bytes of the incoming frame stream into that buffer.
- It closes the buffer when the buffer is full, when the frame ends, or when the stream has been quiet for a programmable time.
- It then writes its advanced read index to a status word in memory and may raise a one-cycle interrupt.

A small register interface holds the channel configuration, the ring base, the write index and the status word address. It also gives back an idle flag and the current read index. The channel can run normally, stop at once, or stop at the next frame boundary. The ring counts as empty of free descriptors whenever the read index equals the write index.

Top module: `rxring_dma`

## Requirements
- R1: In run mode (config bits 31:30 = 2'b10), when descriptors are free, the controller fetches the word at `{ring_base,8'h00} + 4*read_index`, using a read (`mem_we`=0). It loads `buf_addr` with `{desc[27:0],8'h00}`, ignoring descriptor bits 31:28, and then raises `rx_ready`.
- R2: When the read index equals the write index after masking to the ring size, no descriptor is fetched and `rx_ready` stays low.
- R3: A write to the write-index register (address 2) is rounded down to a multiple of 8 before use. Reading address 2 returns the rounded value.
- R4: Config bits 23:20 give log2 of the ring size. Values below 5 act as 5 and values above 12 act as 12. The read index steps by one per closed buffer and wraps from size−1 to 0.
- R5: Config bits 17:16 = s select a buffer of (s+1)·BUF_UNIT bytes. A buffer closes on the beat that brings its byte count to that size.
- R6: A beat with `rx_last` set closes the open buffer, whatever its byte count.
- R7: Config bits 11:4 = T, when nonzero, close a partly filled buffer after T ticks with no accepted byte. A tick is CYC_PER_TICK clock cycles, and each accepted byte restarts the count. T = 0 disables the timeout.
- R8: After a buffer closes, the controller issues a write (`mem_we`=1) to `{status_base,4'h0}`. The write data bits 11:0 hold the advanced read index, and the other bits are 0. Status register (address 4) bits 11:0 return the same index.
- R9: `irq` pulses for exactly one cycle after the status write is granted when config bits 13:12 = 2'b01. It stays low when those bits are 2'b00.
- R10: In mode 2'b00 (writing 0 to the config register), `rx_ready` drops at once. Status register bit 24 reads 1 while no memory request is pending and the stream is not accepted.
- R11: In mode 2'b01, a frame already in progress keeps being accepted, fetching new descriptors if needed. After a beat with `rx_last`, `rx_ready` stays low and no new descriptor is fetched.
- R12: A memory request holds its address and direction stable until `mem_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 config, 1 ring base [35:8], 2 write index, 3 status address [35:4], 4 status (read-only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = status write, 0 = descriptor fetch |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Status write data |
| mem_gnt | input | 1 | Grant; completes the request in this cycle |
| mem_rdata | input | 32 | Descriptor word, valid with grant |
| rx_valid | input | 1 | Stream byte valid |
| rx_last | input | 1 | Last byte of frame |
| rx_ready | output | 1 | Stream byte accepted when high with rx_valid |
| buf_addr | output | 36 | Address of the currently open buffer |
| irq | output | 1 | One-cycle interrupt after status write |

## Verification
The bench builds the block with BUF_UNIT = 16 and CYC_PER_TICK = 4. This makes the four buffer sizes 16 to 64 bytes and a timeout tick four cycles long. As a result, size-limited closes, multi-tick timeouts and many wraps of a 32-entry ring all fit in a short run. The ring-size field is driven below its minimum, so the clamp to 32 entries is what produces the observed wrap. Random frame lengths, random idle gaps, unaligned write-index values and random grant latency are mixed with directed stops, end-of-frame pauses and the full-ring case.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_EOF = 2'b01,
      MODE_RUN = 2'b10,
      MODE_RSV = 2'b11
   } rx_mode_e;

   typedef enum logic [1:0] {
      ST_WAIT,
      ST_FETCH,
      ST_FILL,
      ST_POST
   } rx_state_e;

   localparam int unsigned PHYS_W       = 36;
   localparam int unsigned CFG_MODE_LSB = 30;
   localparam int unsigned CFG_LOG_LSB  = 20;
   localparam int unsigned CFG_SIZE_LSB = 16;
   localparam int unsigned CFG_DEST_LSB = 12;
   localparam int unsigned CFG_TMO_LSB  = 4;
   localparam int unsigned CFG_TMO_W    = 8;
   localparam int unsigned IDLE_BIT     = 24;

   localparam logic [2:0] RA_CFG  = 3'd0;
   localparam logic [2:0] RA_BASE = 3'd1;
   localparam logic [2:0] RA_WIDX = 3'd2;
   localparam logic [2:0] RA_STAT = 3'd3;
   localparam logic [2:0] RA_IDLE = 3'd4;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs import rxr_pkg::*; #(
   parameter int unsigned IDX_W    = 12,
   parameter int unsigned STEP_LOG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [31:0]      wdata,
   input  logic             idle,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      cfg,
   output logic [27:0]      ring_base,
   output logic [IDX_W-1:0] widx,
   output logic [31:0]      stat_base,
   output logic [31:0]      rdata
);
   logic [IDX_W-1:0] widx_in;

   initial begin
      assert (IDX_W <= 32 && STEP_LOG < IDX_W)
         else $error("rxr_regs: bad index parameters");
   end

   generate
      if (STEP_LOG == 0) begin : g_no_round
         assign widx_in = wdata[IDX_W-1:0];
      end else begin : g_round
         assign widx_in = {wdata[IDX_W-1:STEP_LOG], {STEP_LOG{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         ring_base <= '0;
         widx      <= '0;
         stat_base <= '0;
      end else if (we) begin
         case (addr)
            RA_CFG:  cfg       <= wdata;
            RA_BASE: ring_base <= wdata[27:0];
            RA_WIDX: widx      <= widx_in;
            RA_STAT: stat_base <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         RA_CFG:  rdata = cfg;
         RA_BASE: rdata = {4'h0, ring_base};
         RA_WIDX: rdata = 32'(widx);
         RA_STAT: rdata = stat_base;
         RA_IDLE: rdata = 32'(rd_idx) | (32'(idle) << IDLE_BIT);
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int unsigned IDX_W   = 12,
   parameter int unsigned LOG_MIN = 5,
   parameter int unsigned LOG_MAX = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       log_field,
   input  logic [IDX_W-1:0] widx,
   input  logic             advance,
   output logic [IDX_W-1:0] rd_idx,
   output logic             avail
);
   logic [3:0]       eff_log;
   logic [IDX_W:0]   one_sh;
   logic [IDX_W-1:0] mask;

   initial begin
      assert (LOG_MIN >= 1 && LOG_MIN <= LOG_MAX && LOG_MAX <= IDX_W && LOG_MAX < 16)
         else $error("rxr_ring_ptr: bad ring size limits");
   end

   always_comb begin
      if (log_field < 4'(LOG_MIN))      eff_log = 4'(LOG_MIN);
      else if (log_field > 4'(LOG_MAX)) eff_log = 4'(LOG_MAX);
      else                              eff_log = log_field;
   end

   assign one_sh = (IDX_W+1)'(1) << eff_log;
   assign mask   = one_sh[IDX_W-1:0] - IDX_W'(1);
   assign avail  = (widx & mask) != rd_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_idx <= '0;
      else if (advance) rd_idx <= (rd_idx + IDX_W'(1)) & mask;
   end

   // R4
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> rd_idx == (($past(rd_idx) + IDX_W'(1)) & $past(mask)))
      else $error("read index did not step by one modulo ring size");

   // R4
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(rd_idx))
      else $error("read index moved without a closed buffer");
endmodule

// File: rtl/rxr_close_timer.sv
module rxr_close_timer #(
   parameter int unsigned CYC_PER_TICK = 1600,
   parameter int unsigned TMO_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             kick,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic             tick;
   logic [TMO_W-1:0] cnt;

   initial begin
      assert (CYC_PER_TICK >= 1) else $error("rxr_close_timer: tick must be >= 1 cycle");
   end

   generate
      if (CYC_PER_TICK == 1) begin : g_direct
         assign tick = arm && !kick;
      end else begin : g_prescale
         localparam int unsigned PS_W = $clog2(CYC_PER_TICK);
         logic [PS_W-1:0] pcnt;
         assign tick = arm && !kick && (pcnt == PS_W'(CYC_PER_TICK - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pcnt <= '0;
            else if (!arm || kick || tick) pcnt <= '0;
            else                       pcnt <= pcnt + PS_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (!arm || kick)           cnt <= '0;
      else if (tick && cnt != limit)   cnt <= cnt + TMO_W'(1);
   end

   assign expire = arm && (limit != '0) && (cnt == limit);

   // R7
   tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !expire)
      else $error("timeout fired right after an accepted byte");
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma import rxr_pkg::*; #(
   parameter int unsigned IDX_W        = 12,
   parameter int unsigned LOG_MIN      = 5,
   parameter int unsigned LOG_MAX      = 12,
   parameter int unsigned STEP_LOG     = 3,
   parameter int unsigned BUF_UNIT     = 4096,
   parameter int unsigned CYC_PER_TICK = 1600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PHYS_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   input  logic              rx_valid,
   input  logic              rx_last,
   output logic              rx_ready,
   output logic [PHYS_W-1:0] buf_addr,
   output logic              irq
);
   localparam int unsigned FILL_W = $clog2(4 * BUF_UNIT) + 1;

   initial begin
      assert (BUF_UNIT >= 1 && IDX_W <= 30)
         else $error("rxring_dma: bad buffer or index parameters");
   end

   logic [31:0]       cfg;
   logic [27:0]       ring_base;
   logic [IDX_W-1:0]  widx;
   logic [IDX_W-1:0]  rd_idx;
   logic [31:0]       stat_base;
   rx_mode_e          mode;
   logic [1:0]        size_sel;
   logic [1:0]        dest;
   logic [3:0]        log_f;
   logic [CFG_TMO_W-1:0] tmo_lim;
   rx_state_e         state;
   logic              in_frame, accept_en, beat, last_byte, close;
   logic              tmo_fire, idle, avail, arm;
   logic [FILL_W-1:0] fill, buf_bytes;

   assign mode     = rx_mode_e'(cfg[CFG_MODE_LSB +: 2]);
   assign size_sel = cfg[CFG_SIZE_LSB +: 2];
   assign dest     = cfg[CFG_DEST_LSB +: 2];
   assign log_f    = cfg[CFG_LOG_LSB +: 4];
   assign tmo_lim  = cfg[CFG_TMO_LSB +: CFG_TMO_W];

   rxr_regs #(.IDX_W(IDX_W), .STEP_LOG(STEP_LOG)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .idle(idle), .rd_idx(rd_idx), .cfg(cfg), .ring_base(ring_base),
      .widx(widx), .stat_base(stat_base), .rdata(reg_rdata)
   );

   rxr_ring_ptr #(.IDX_W(IDX_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX)) ptr_i (
      .clk(clk), .rst_n(rst_n), .log_field(log_f), .widx(widx),
      .advance(close), .rd_idx(rd_idx), .avail(avail)
   );

   rxr_close_timer #(.CYC_PER_TICK(CYC_PER_TICK), .TMO_W(CFG_TMO_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .kick(beat),
      .limit(tmo_lim), .expire(tmo_fire)
   );

   assign accept_en = (mode == MODE_RUN) || (mode == MODE_EOF && in_frame);
   assign rx_ready  = (state == ST_FILL) && accept_en;
   assign beat      = rx_ready && rx_valid;
   assign buf_bytes = FILL_W'(BUF_UNIT) * FILL_W'({1'b0, size_sel} + 3'd1);
   assign last_byte = beat && (rx_last || (fill + FILL_W'(1)) >= buf_bytes);
   assign arm       = (state == ST_FILL) && (fill != '0);
   assign close     = last_byte || (arm && tmo_fire && !beat);
   assign idle      = (state == ST_WAIT || state == ST_FILL) && !accept_en;

   assign mem_req   = (state == ST_FETCH) || (state == ST_POST);
   assign mem_we    = (state == ST_POST);

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      if (state == ST_FETCH) begin
         mem_addr = {ring_base, 8'h00} + PHYS_W'({rd_idx, 2'b00});
      end else if (state == ST_POST) begin
         mem_addr  = {stat_base, 4'h0};
         mem_wdata = 32'(rd_idx);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_WAIT;
         fill     <= '0;
         in_frame <= 1'b0;
         buf_addr <= '0;
         irq      <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (beat) in_frame <= !rx_last;
         case (state)
            ST_WAIT:  if (avail && accept_en) state <= ST_FETCH;
            ST_FETCH: if (mem_gnt) begin
                         buf_addr <= {mem_rdata[27:0], 8'h00};
                         fill     <= '0;
                         state    <= ST_FILL;
                      end
            ST_FILL:  begin
                         if (beat)  fill  <= fill + FILL_W'(1);
                         if (close) state <= ST_POST;
                      end
            ST_POST:  if (mem_gnt) begin
                         state <= ST_WAIT;
                         irq   <= (dest == 2'b01);
                      end
            default:  state <= ST_WAIT;
         endcase
      end
   end

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
      else $error("memory request changed before grant");

   // R10
   ready_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (mode == MODE_RUN || mode == MODE_EOF))
      else $error("stream accepted while channel stopped");

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(mem_req && mem_we && mem_gnt))
      else $error("interrupt without a granted status write");

   // R11
   eof_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_EOF && $past(mode == MODE_EOF) && $past(rx_valid && rx_ready && rx_last))
      |-> !rx_ready)
      else $error("stream still accepted after frame end in pause-at-frame-end mode");
endmodule

// File: tb/rxring_dma_tb_top.sv
module rxring_dma_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BUF_UNIT   = 16;
   localparam int TICK       = 4;
   localparam logic [27:0] RING_BASE = 28'h0012345;
   localparam logic [31:0] STAT_BASE = 32'h00ABCDE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_gnt;
   logic [35:0] mem_addr, buf_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready, irq;

   int checks = 0, fails = 0;
   int exp_r = 0, exp_mask = 31;
   int drv_r = 0, drv_w = 0, drv_fill = 0, bufb = 16;
   int wb_cnt = 0, fetch_cnt = 0, wrap_cnt = 0, irq_cnt = 0, wcnt = 0;
   int fetch_idx = 0;
   bit was_fetch = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxring_dma #(.BUF_UNIT(BUF_UNIT), .CYC_PER_TICK(TICK)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .rx_valid(rx_valid),
      .rx_last(rx_last), .rx_ready(rx_ready), .buf_addr(buf_addr), .irq(irq)
   );

   function automatic logic [31:0] desc_f(input int i);
      return 32'hA000_0000 | ((32'(i) * 32'h0001_0203 + 32'h0055_0000) & 32'h0FFF_FFFF);
   endfunction

   function automatic logic [31:0] mk_cfg(input logic [1:0] m, input logic [3:0] lg,
                                          input logic [1:0] sz, input logic [1:0] ds,
                                          input logic [7:0] tm);
      return {m, 6'b0, lg, 2'b0, sz, 2'b0, ds, tm, 4'b0};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_cfg(input logic [31:0] c);
      wr(3'd0, c);
      bufb = BUF_UNIT * (int'(c[17:16]) + 1);
   endtask

   // one stream byte; checks whether the buffer closes on it (R5, R6)
   task automatic send(input bit lst);
      int guard = 0;
      bit acc;
      bit exp_close;
      @(negedge clk);
      rx_valid = 1'b1; rx_last = lst;
      acc = rx_ready;
      while (!acc && guard < 3000) begin
         @(negedge clk);
         guard++;
         acc = rx_ready;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      if (!acc) begin
         check(1'b0, "R1", "byte never accepted", 0, 1);
         return;
      end
      exp_close = lst || (drv_fill + 1 >= bufb);
      check((mem_req && mem_we) == exp_close, lst ? "R6" : "R5",
            "buffer close after byte", longint'(mem_req && mem_we), longint'(exp_close));
      if (exp_close) begin
         drv_fill = 0;
         drv_r = (drv_r + 1) & exp_mask;
      end else begin
         drv_fill++;
      end
   endtask

   // memory model: random grant latency, checks every granted request
   initial begin
      mem_gnt = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_gnt) begin
            mem_gnt = 1'b0; mem_rdata = '0;
            if (was_fetch) begin
               logic [31:0] dw;
               dw = desc_f(fetch_idx);
               check(buf_addr == {dw[27:0], 8'h00}, "R1", "buffer address from descriptor",
                     longint'(buf_addr), longint'({dw[27:0], 8'h00}));
            end
         end else if (mem_req) begin
            if (wcnt > 0) wcnt--;
            else begin
               mem_gnt = 1'b1;
               wcnt = $urandom_range(0, 2);
               if (!mem_we) begin
                  logic [35:0] ea;
                  ea = {RING_BASE, 8'h00} + 36'(exp_r * 4);
                  check(mem_addr == ea, "R1", "descriptor fetch address",
                        longint'(mem_addr), longint'(ea));
                  mem_rdata = desc_f(exp_r);
                  fetch_idx = exp_r;
                  was_fetch = 1;
                  fetch_cnt++;
               end else begin
                  int nr;
                  nr = (exp_r + 1) & exp_mask;
                  check(mem_addr == {STAT_BASE, 4'h0}, "R8", "status write address",
                        longint'(mem_addr), longint'({STAT_BASE, 4'h0}));
                  check(mem_wdata == 32'(nr), "R8", "status write index",
                        longint'(mem_wdata), longint'(nr));
                  exp_r = nr;
                  wb_cnt++;
                  if (nr == 0) wrap_cnt++;
                  was_fetch = 0;
               end
            end
         end
      end
   end

   always @(negedge clk) if (irq) irq_cnt++;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int k, irq0, wb0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check(!rx_ready && !mem_req && !irq, "R10", "outputs quiet after reset",
            longint'({rx_ready, mem_req, irq}), 0);
      rd(3'd4, v);
      check(v == 32'h0100_0000, "R10", "status idle after reset", longint'(v), 32'h0100_0000);

      wr(3'd1, {4'h0, RING_BASE});
      wr(3'd3, STAT_BASE);
      // log2 field 2 clamps to 5 -> 32 entries
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd0, 2'b01, 8'd0));
      repeat (8) @(negedge clk);
      check(!mem_req && fetch_cnt == 0 && !rx_ready, "R2", "no fetch when read == write",
            longint'(fetch_cnt), 0);

      // unaligned write index rounds down
      wr(3'd2, 32'd13);
      drv_w = 8;
      rd(3'd2, v);
      check(v == 32'd8, "R3", "write index rounded", longint'(v), 8);
      k = 0;
      while (!rx_ready && k < 50) begin @(negedge clk); k++; end
      check(rx_ready, "R1", "ready after descriptor fetch", longint'(rx_ready), 1);

      // full 16-byte buffer
      for (int i = 0; i < 16; i++) send(1'b0);
      repeat (10) @(negedge clk);
      check(irq_cnt == 1, "R9", "irq after status write", irq_cnt, 1);

      // short frame
      for (int i = 0; i < 5; i++) send(i == 4);

      // larger buffer: 32 bytes
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd1, 2'b01, 8'd0));
      for (int i = 0; i < 32; i++) send(1'b0);

      // timeout of 3 ticks
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd1, 2'b01, 8'd3));
      send(1'b0); send(1'b0);
      k = 0;
      while (!(mem_req && mem_we) && k < 40) begin @(negedge clk); k++; end
      check(k >= 8 && k <= 20, "R7", "timeout close delay", k, 12);
      drv_fill = 0; drv_r = (drv_r + 1) & exp_mask;
      repeat (5) @(negedge clk);

      // no interrupt with destination none
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd1, 2'b00, 8'd0));
      irq0 = irq_cnt;
      send(1'b1);
      repeat (10) @(negedge clk);
      check(irq_cnt == irq0, "R9", "no irq with destination none", irq_cnt, irq0);

      // pause at end of frame
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd1, 2'b01, 8'd0));
      send(1'b0);
      set_cfg(mk_cfg(2'b01, 4'd2, 2'd1, 2'b01, 8'd0));
      repeat (2) @(negedge clk);
      check(rx_ready, "R11", "mid-frame still accepted", longint'(rx_ready), 1);
      send(1'b1);
      repeat (10) @(negedge clk);
      check(!rx_ready && !mem_req, "R11", "paused after frame end",
            longint'({rx_ready, mem_req}), 0);
      rd(3'd4, v);
      check(v[24] == 1'b1, "R10", "idle flag in pause", longint'(v[24]), 1);

      // immediate stop
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd1, 2'b01, 8'd0));
      send(1'b0);
      set_cfg(32'h0);
      repeat (2) @(negedge clk);
      rd(3'd4, v);
      check(!rx_ready && v[24], "R10", "stop drops ready and sets idle",
            longint'({rx_ready, v[24]}), 1);
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd1, 2'b01, 8'd0));
      send(1'b1);

      // ring full: read reaches write index 8
      send(1'b1);
      repeat (10) @(negedge clk);
      check(!rx_ready && !mem_req, "R2", "stall when ring exhausted",
            longint'({rx_ready, mem_req}), 0);
      rd(3'd4, v);
      check(v[11:0] == 12'd8, "R8", "read index in status register", longint'(v[11:0]), 8);

      // random traffic with unaligned write-index updates
      set_cfg(mk_cfg(2'b10, 4'd2, 2'd0, 2'b01, 8'd0));
      for (int i = 0; i < 500; i++) begin
         if (drv_fill == 0 && drv_r == drv_w) begin
            drv_w = (drv_w + 8) & exp_mask;
            wr(3'd2, 32'(drv_w | int'($urandom_range(0, 7))));
         end
         repeat ($urandom_range(0, 2)) @(negedge clk);
         send($urandom_range(0, 4) == 0);
      end
      repeat (20) @(negedge clk);
      check(wrap_cnt > 0, "R4", "read index wrapped at 32", wrap_cnt, 1);
      wb0 = wb_cnt;
      check(irq_cnt == wb0 - 1, "R9", "one irq per status write", irq_cnt, wb0 - 1);
      rd(3'd4, v);
      check(int'(v[11:0]) == drv_r, "R4", "final read index", longint'(v[11:0]), drv_r);

      done = 1;
      report();
      $finish;
   end
endmodule